// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a binary up-counter built from identical 4-bit slices. Each slice has a synchronous active-low clear and a synchronous active-low parallel load. It counts only when two enables are both high. The first enable, P, is shared by all slices. The second enable, T, is chained: each slice's carry output drives the T input of the slice above it. Because of this, all slices change on the same clock edge, so the whole chain behaves as one wide synchronous counter.

The slice's carry output is combinational. It is the AND of that slice's T enable with all of its count bits, so it follows T without waiting for a clock edge. Enable P plays no part in the carry. This lets the P inputs of every slice be driven in parallel while T carries the ripple through the chain.

The top module joins a parameterised number of slices into a wider counter. It exposes the full count, the full load value and the carry out of the last slice. Only the clear gives the count a defined value. The count is undefined until the first edge at which clear is sampled low.

Top module: `casc_counter`

## Requirements
- R1: When clr_n is low at a rising edge, the whole count becomes 0, whatever ld_n, the enables and load_val are.
- R2: When clr_n is high and ld_n is low at a rising edge, count takes load_val (bit 0 is the least significant bit), whatever the enables are.
- R3: When clr_n, ld_n, en_p and en_t are all high at a rising edge, count increases by one.
- R4: When clr_n and ld_n are high and either en_p or en_t is low at a rising edge, count holds its value.
- R5: carry_out is high exactly when en_t is high and every count bit is 1. It follows a change of en_t within the same cycle, with no clock edge needed.
- R6: en_p has no effect on carry_out.
- R7: A load takes effect only on an edge at which ld_n is sampled low. On the next edge, with ld_n high, the loaded value counts normally.
- R8: A slice advances on the same edge on which the slice below it wraps from 15 to 0, so the chain counts as one binary number.
- R9: An increment from all ones wraps the count to 0, and carry_out then drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable shared by all slices; does not gate the carry |
| en_t | input | 1 | Count enable of the lowest slice; gates the carry |
| load_val | input | 4*STAGES | Value taken by a load, bit 0 least significant |
| count | output | 4*STAGES | Current count |
| carry_out | output | 1 | Carry out of the last slice |

## Verification
The bench builds the counter with two slices, an 8-bit count. This keeps every value within reach of an exhaustive sweep. Every load value is applied once, with the enables varied alongside it. A full count is run from 0 through 255 and back to 0. This covers the nibble boundary where the upper slice must advance on the same edge the lower slice wraps, and the final wrap where the carry drops. Directed steps cover clear overriding load, holds on each enable, a carry that does not depend on P, and a carry that follows T with no clock edge.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef logic [SLICE_W-1:0] slice_t;

  // Operation chosen at an edge; clear beats load beats count.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/casc_counter_op.sv
module casc_counter_op
  import casc_counter_pkg::*;
(
  input  logic clr_n,
  input  logic ld_n,
  input  logic en_p,
  input  logic en_t,
  output op_e  op
);
  always_comb begin
    if (!clr_n)           op = OP_CLEAR;
    else if (!ld_n)       op = OP_LOAD;
    else if (en_p && en_t) op = OP_INC;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/casc_counter_slice.sv
module casc_counter_slice
  import casc_counter_pkg::*;
(
  input  logic   clk,
  input  logic   clr_n,
  input  logic   ld_n,
  input  logic   en_p,
  input  logic   en_t,
  input  slice_t din,
  output slice_t q,
  output logic   co
);
  op_e    op;
  slice_t q_nxt;
  logic   q_en;

  casc_counter_op u_op (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  // Next state and clock enable.
  always_comb begin
    q_nxt = q;
    q_en  = 1'b1;
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_INC:   q_nxt = q + slice_t'(1);
      default:  q_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (q_en) q <= q_nxt;
  end

  // Carry: combinational from T and the count; P is not involved.
  assign co = en_t & (&q);

  assert_clear_zero_R1: assert property (@(posedge clk)
    !clr_n |=> q == '0);
  assert_load_value_R2: assert property (@(posedge clk)
    (clr_n && !ld_n) |=> q == $past(din));
  assert_increment_R3: assert property (@(posedge clk)
    (clr_n && ld_n && en_p && en_t) |=> q == slice_t'($past(q) + slice_t'(1)));
  assert_hold_R4: assert property (@(posedge clk)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
  assert_carry_gated_R5: assert property (@(posedge clk)
    !en_t |-> !co);
  assert_carry_full_R5: assert property (@(posedge clk)
    co |-> (q == '1));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        ld_n,
  input  logic                        en_p,
  input  logic                        en_t,
  input  logic [SLICE_W*STAGES-1:0]   load_val,
  output logic [SLICE_W*STAGES-1:0]   count,
  output logic                        carry_out
);
  localparam int unsigned TOTAL_W = SLICE_W * STAGES;

  logic [STAGES:0] t_chain;

  assign t_chain[0] = en_t;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    slice_t q_s;

    casc_counter_slice u_slice (
      .clk   (clk),
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (t_chain[s]),
      .din   (load_val[s*SLICE_W +: SLICE_W]),
      .q     (q_s),
      .co    (t_chain[s+1])
    );

    assign count[s*SLICE_W +: SLICE_W] = q_s;
  end

  assign carry_out = t_chain[STAGES];

  assert_chain_carry_R5: assert property (@(posedge clk)
    carry_out |-> (en_t && count == '1));
  assert_chain_increment_R8: assert property (@(posedge clk)
    (clr_n && ld_n && en_p && en_t) |=>
      count == TOTAL_W'($past(count) + TOTAL_W'(1)));
  assert_chain_wrap_R9: assert property (@(posedge clk)
    (clr_n && ld_n && en_p && en_t && count == '1) |=> (count == '0 && !carry_out));
endmodule

// File: tb/casc_counter_bench.sv
module casc_counter_bench;
  localparam int N    = 2;
  localparam int W    = 4 * N;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr_n, ld_n, en_p, en_t;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic         carry_out;
  logic [W-1:0] model_q;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  always #5 clk = ~clk;

  casc_counter #(.STAGES(N)) u_casc_counter (
    .clk       (clk),
    .clr_n     (clr_n),
    .ld_n      (ld_n),
    .en_p      (en_p),
    .en_t      (en_t),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check the carry there, then check the count after the edge.
  task automatic step(input string req, input logic c, input logic l,
                      input logic p, input logic t, input logic [W-1:0] v);
    @(negedge clk);
    clr_n = c; ld_n = l; en_p = p; en_t = t; load_val = v;
    #1;
    chk("R5 R6 carry", W'(carry_out), W'(t && model_q == W'(MAXV)));
    if (!c)          model_q = '0;
    else if (!l)     model_q = v;
    else if (p && t) model_q = model_q + W'(1);
    @(posedge clk);
    #1;
    chk(req, count, model_q);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected below 20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    clr_n = 1'b0; ld_n = 1'b0; en_p = 1'b1; en_t = 1'b0; load_val = '0;
    model_q = '0;
    @(posedge clk);
    #1;
    // R1: the first clear defines the count.
    chk("R1 reset", count, '0);
    step("R1 clear with load low", 1'b0, 1'b0, 1'b1, 1'b1, W'('hA5));

    // R2: exhaustive load, enables varied.
    for (int v = 0; v <= MAXV; v++)
      step("R2 load", 1'b1, 1'b0, v[0], v[1], W'(v));

    // R1: clear wins over load.
    step("R1 clear over load", 1'b0, 1'b0, 1'b1, 1'b1, W'('h3C));

    // R3 R8 R9: full sweep including nibble boundary and wrap.
    for (int i = 0; i <= MAXV; i++)
      step("R3 R8 R9 count", 1'b1, 1'b1, 1'b1, 1'b1, W'('h55));
    chk("R9 wrapped to zero", count, '0);

    // R4: hold on each enable.
    step("R2 preload", 1'b1, 1'b0, 1'b0, 1'b0, W'('h7E));
    step("R4 hold P low", 1'b1, 1'b1, 1'b0, 1'b1, W'('h00));
    step("R4 hold T low", 1'b1, 1'b1, 1'b1, 1'b0, W'('h00));
    step("R4 hold both low", 1'b1, 1'b1, 1'b0, 1'b0, W'('hFF));

    // R6: carry at all ones with P low; count holds.
    step("R2 preload max", 1'b1, 1'b0, 1'b1, 1'b1, W'(MAXV));
    step("R6 hold P low at max", 1'b1, 1'b1, 1'b0, 1'b1, W'('h00));

    // R5: carry follows T without an edge.
    @(negedge clk);
    en_t = 1'b0;
    #1;
    chk("R5 carry drops with T", W'(carry_out), W'(0));
    en_t = 1'b1;
    #1;
    chk("R5 carry rises with T", W'(carry_out), W'(1));
    en_p = 1'b0;
    #1;
    chk("R6 carry ignores P", W'(carry_out), W'(1));

    // R7: load on one edge only, then count.
    step("R7 load edge", 1'b1, 1'b0, 1'b1, 1'b1, W'('h40));
    step("R7 count after load", 1'b1, 1'b1, 1'b1, 1'b1, W'('h99));
    chk("R7 value after release", count, W'('h41));

    // R8: boundary of lower slice.
    step("R2 preload 0F", 1'b1, 1'b0, 1'b1, 1'b1, W'('h0F));
    step("R8 upper advances", 1'b1, 1'b1, 1'b1, 1'b1, W'('h00));
    chk("R8 value 10", count, W'('h10));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule